// File: doc/BRIEF.md
# Timer Input Capture Unit with Byte-Serial 16-bit Access

This block pairs a free-running 16-bit counter with an input capture register, two compare registers and a four-source flag and interrupt set. A capture event copies the counter into the capture register. The event is an edge, of a polarity chosen by software, on either an external pin or an internal comparator output, and a control bit picks between the two. Capture, overflow and the two compare matches each set a flag. Each flag raises an interrupt line only while its local enable bit and the global interrupt enable are both one.

Software reaches the unit over an 8-bit register bus. Every 16-bit register is moved one byte at a time through a single shared byte-wide holding register. A low-byte read snapshots the high byte. A high-byte write is parked until the matching low-byte write commits both halves in one cycle. A 16-bit value therefore never tears while the counter keeps running.

Top module: `icu_timer`

## Requirements
- R1: After reset the counter, capture register, mask, flags, control, holding register and read data are zero, both compare registers are 0xFFFF and all interrupt lines are low.
- R2: The counter increments once per clock and wraps from 0xFFFF to 0x0000. The wrap sets the overflow flag, which is bit 0 of the flag register at address 9.
- R3: If the selected source makes its active edge while the counter shows C, the capture register holds C+2 three clocks later, set by a two-stage synchroniser. Capture also sets the capture flag, bit 5 of the flag register.
- R4: Control bit 1 at address 10 selects the active edge: 1 means rising and 0 means falling. The opposite edge captures nothing and sets no flag.
- R5: Control bit 0 selects the source: 0 is the pin and 1 is the comparator. Edges on the source that is not selected have no effect.
- R6: The low bytes sit at addresses 0 (counter), 2 (capture), 4 (compare A) and 6 (compare B), and the high bytes one above each. Reading a low byte returns it and loads the high byte of that same value into the holding register. Reading any high-byte address returns the holding register, with read data valid one clock after the request.
- R7: A high-byte write only loads the holding register. A low-byte write stores {holding register, written byte} into the addressed 16-bit register. One holding register serves all four 16-bit registers.
- R8: The mask register at address 9-1=8 keeps bits 5 (capture), 2 (compare B), 1 (compare A) and 0 (overflow). Bits 7, 6, 4 and 3 always read zero.
- R9: Flag bits use the same positions as the mask. Writing one to a flag bit clears that flag, and writing zero leaves it unchanged.
- R10: irq[0] (overflow), irq[1] (compare A), irq[2] (compare B) and irq[3] (capture) each go high one clock after the matching flag, mask bit and gie are all one. Each line drops one clock after any of the three goes to zero.
- R11: A one-clock pulse on irq_ack[k] clears the flag behind irq[k], using the same bit order as irq.
- R12: A compare flag (bit 1 for A, bit 2 for B) sets when the counter equals that compare register. It does not set while the counter stays below the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | External capture input, asynchronous |
| cmp_in | input | 1 | Internal comparator output, asynchronous |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 4 | Per-source interrupt acknowledge pulses |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, takes precedence over read |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 4 | Registered interrupt requests |

## Verification
The bench builds the unit with its defaults: an 8-bit bus, a 16-bit counter and two synchroniser stages. With those values the capture latency of exactly two counts can be predicted from a counter model kept in the bench. Loading the counter to 0xFFF0 through the byte path brings the wrap and a compare match near the top of the range within a few dozen clocks. Random 16-bit write and read-back traffic, plus cross-register use of the holding register, covers the shared snapshot path.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam logic [3:0] ADR_CNT_L = 4'd0;
  localparam logic [3:0] ADR_CAP_L = 4'd2;
  localparam logic [3:0] ADR_MASK  = 4'd8;
  localparam logic [3:0] ADR_FLAG  = 4'd9;
  localparam logic [3:0] ADR_CTRL  = 4'd10;

  localparam int NSRC  = 4;
  localparam int S_OVF = 0;
  localparam int S_CMA = 1;
  localparam int S_CMB = 2;
  localparam int S_CAP = 3;

  // Internal source order -> byte view seen on the bus
  function automatic logic [7:0] src_view(input logic [NSRC-1:0] v);
    return {2'b00, v[S_CAP], 2'b00, v[S_CMB], v[S_CMA], v[S_OVF]};
  endfunction
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/icu_edge.sv
module icu_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  input  logic rise_sel,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig;
  end

  assign evt = rise_sel ? (sig & ~prev_q) : (~sig & prev_q);
endmodule

// File: rtl/icu_flags.sv
module icu_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  input  logic         gie,
  output logic [N-1:0] flags,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
        irq[i]   <= 1'b0;
      end else begin
        flags[i] <= set[i] | (flags[i] & ~clr[i]);
        irq[i]   <= flags[i] & mask[i] & gie;
      end
    end
  end
endmodule

// File: rtl/icu_timer.sv
module icu_timer
  import icu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [2*DATA_W-1:0] CMP_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_pin,
  input  logic              cmp_in,
  input  logic              gie,
  input  logic [NSRC-1:0]   irq_ack,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NSRC-1:0]   irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt_q, cap_q, cmpa_q, cmpb_q, word_sel, commit;
  logic [DATA_W-1:0] temp_q, rd_mux;
  logic [NSRC-1:0]   mask_q, flags_q, flag_set, flag_clr, wr_view;
  logic [1:0]        ctrl_q, src_sync;
  logic              is_lo16, is_hi16, rd_go, wr_cnt, cap_evt, src_sig;

  // Source synchroniser and edge detector
  icu_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({cmp_in, cap_pin}), .q(src_sync)
  );
  assign src_sig = ctrl_q[0] ? src_sync[1] : src_sync[0];
  icu_edge u_edge (
    .clk(clk), .rst(rst), .sig(src_sig), .rise_sel(ctrl_q[1]), .evt(cap_evt)
  );

  // Bus decode
  assign is_lo16 = (bus_addr < 4'd8) && !bus_addr[0];
  assign is_hi16 = (bus_addr < 4'd8) &&  bus_addr[0];
  assign rd_go   = bus_rd && !bus_wr;
  assign commit  = {temp_q, bus_wdata};
  assign wr_cnt  = bus_wr && (bus_addr == ADR_CNT_L);
  assign wr_view = {bus_wdata[5], bus_wdata[2:0]};

  always_comb begin
    case (bus_addr[2:1])
      2'd0:    word_sel = cnt_q;
      2'd1:    word_sel = cap_q;
      2'd2:    word_sel = cmpa_q;
      default: word_sel = cmpb_q;
    endcase
  end

  // Counter and 16-bit registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      cmpa_q <= CMP_INIT;
      cmpb_q <= CMP_INIT;
    end else begin
      cnt_q <= wr_cnt ? commit : cnt_q + 1'b1;
      if (cap_evt)                             cap_q  <= cnt_q;
      else if (bus_wr && bus_addr == 4'd2)     cap_q  <= commit;
      if (bus_wr && bus_addr == 4'd4)          cmpa_q <= commit;
      if (bus_wr && bus_addr == 4'd6)          cmpb_q <= commit;
    end
  end

  // Shared holding register
  always_ff @(posedge clk) begin
    if (rst)                  temp_q <= '0;
    else if (bus_wr && is_hi16) temp_q <= bus_wdata;
    else if (rd_go && is_lo16)  temp_q <= word_sel[CNT_W-1:DATA_W];
  end

  // Mask and control
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADR_MASK) mask_q <= wr_view;
      if (bus_addr == ADR_CTRL) ctrl_q <= bus_wdata[1:0];
    end
  end

  // Flags and interrupts
  always_comb begin
    flag_set        = '0;
    flag_set[S_OVF] = (cnt_q == '1) && !wr_cnt;
    flag_set[S_CMA] = (cnt_q == cmpa_q);
    flag_set[S_CMB] = (cnt_q == cmpb_q);
    flag_set[S_CAP] = cap_evt;
    flag_clr        = irq_ack | ((bus_wr && bus_addr == ADR_FLAG) ? wr_view : '0);
  end

  icu_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr),
    .mask(mask_q), .gie(gie), .flags(flags_q), .irq(irq)
  );

  // Registered read path
  always_comb begin
    if (is_lo16)      rd_mux = word_sel[DATA_W-1:0];
    else if (is_hi16) rd_mux = temp_q;
    else begin
      case (bus_addr)
        ADR_MASK: rd_mux = DATA_W'(src_view(mask_q));
        ADR_FLAG: rd_mux = DATA_W'(src_view(flags_q));
        ADR_CTRL: rd_mux = DATA_W'(ctrl_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/icu_timer_chk.sv
module icu_timer_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                gie,
  input logic [3:0]          bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [3:0]          irq,
  input logic [2*DATA_W-1:0] cnt_q,
  input logic [2*DATA_W-1:0] cap_q,
  input logic [2*DATA_W-1:0] cmpa_q,
  input logic [DATA_W-1:0]   temp_q,
  input logic [3:0]          mask_q,
  input logic [3:0]          flags_q,
  input logic                cap_evt
);
  a_r3_capture_value: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_q == $past(cnt_q));

  a_r2_overflow_flag: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '1 && !(bus_wr && bus_addr == 4'd0)) |=> flags_q[0]);

  a_r6_lo_read_snapshot: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == 4'd2) |=> temp_q == $past(cap_q[2*DATA_W-1:DATA_W]));

  a_r7_lo_write_commit: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 4'd4) |=> cmpa_q == $past({temp_q, bus_wdata}));

  a_r8_mask_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && !bus_wr && bus_addr == 4'd8) |-> (bus_rdata[7:6] == 2'b00 && bus_rdata[4:3] == 2'b00));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    (irq & ~$past(flags_q & mask_q & {4{gie}})) == 4'b0000);
endmodule

bind icu_timer icu_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .gie(gie), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .cnt_q(cnt_q), .cap_q(cap_q), .cmpa_q(cmpa_q), .temp_q(temp_q),
  .mask_q(mask_q), .flags_q(flags_q), .cap_evt(cap_evt)
);

// File: tb/icu_timer_test.sv
`timescale 1ns/1ps
module icu_timer_test;
  logic       clk = 1'b0, rst = 1'b1, cap_pin = 1'b0, cmp_in = 1'b0, gie = 1'b0;
  logic [3:0] irq_ack = 4'h0, bus_addr = 4'h0, irq;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;

  int checks = 0, errors = 0;
  logic [15:0] sh_cnt = 16'h0;
  logic [7:0]  sh_hi = 8'h0;
  bit done = 1'b0;

  icu_timer uut (.*);

  always #2.5 clk = ~clk;

  // One clock; bench model of the free-running counter per R2/R7
  task automatic tick();
    @(posedge clk);
    if (rst) sh_cnt = 16'h0;
    else if (bus_wr && bus_addr == 4'd0) sh_cnt = {sh_hi, bus_wdata};
    else sh_cnt = sh_cnt + 16'd1;
    if (bus_wr && bus_addr < 4'd8 && bus_addr[0]) sh_hi = bus_wdata;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(a + 4'd1, v[15:8]);
    wr(a, v[7:0]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    v = {hi, lo};
  endtask

  // Expected capture after an edge driven while the counter shows c (R3)
  function automatic logic [15:0] cap_expect(input logic [15:0] c);
    return c + 16'd2;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w, e;
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);

    ticks(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", {24'h0, bus_rdata}, 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);
    rd(4'd8, b);  chk("R1 mask", {24'h0, b}, 32'h0);
    rd(4'd9, b);  chk("R1 flags", {24'h0, b}, 32'h0);
    rd(4'd10, b); chk("R1 ctrl", {24'h0, b}, 32'h0);
    rd16(4'd2, w); chk("R1 capture", {16'h0, w}, 32'h0);
    rd16(4'd4, w); chk("R1 compare A", {16'h0, w}, 32'hFFFF);
    rd16(4'd6, w); chk("R1 compare B", {16'h0, w}, 32'hFFFF);

    // R2/R6 counter snapshot held across many clocks
    e = sh_cnt; rd(4'd0, b); ticks(300); rd(4'd1, w[15:8]); w[7:0] = b;
    chk("R6 counter snapshot", {16'h0, w}, {16'h0, e});
    e = sh_cnt; rd16(4'd0, w);
    chk("R2 counter running", {16'h0, w}, {16'h0, e});

    // R7 holding register shared across registers
    wr(4'd5, 8'h5A); rd(4'd3, b);
    chk("R7 shared high byte", {24'h0, b}, 32'h5A);
    wr(4'd2, 8'h33); rd16(4'd2, w);
    chk("R7 commit via shared temp", {16'h0, w}, 32'h5A33);

    // R3 rising-edge capture on pin
    wr(4'd10, 8'h02);
    e = cap_expect(sh_cnt); cap_pin = 1'b1; ticks(3);
    rd16(4'd2, w); chk("R3 capture value", {16'h0, w}, {16'h0, e});
    rd(4'd9, b);   chk("R3 capture flag", {24'h0, b}, 32'h20);
    wr(4'd9, 8'h20); rd(4'd9, b); chk("R9 write-one clear", {24'h0, b}, 32'h0);

    // R4 opposite edge ignored, then falling mode
    cap_pin = 1'b0; ticks(5);
    rd(4'd9, b); chk("R4 falling ignored in rising mode", {24'h0, b}, 32'h0);
    rd16(4'd2, w); chk("R4 capture unchanged", {16'h0, w}, {16'h0, e});
    wr(4'd10, 8'h00);
    cap_pin = 1'b1; ticks(5);
    rd(4'd9, b); chk("R4 rising ignored in falling mode", {24'h0, b}, 32'h0);
    e = cap_expect(sh_cnt); cap_pin = 1'b0; ticks(3);
    rd16(4'd2, w); chk("R4 falling capture", {16'h0, w}, {16'h0, e});
    wr(4'd9, 8'hFF);

    // R5 comparator source
    wr(4'd10, 8'h03);
    cap_pin = 1'b1; ticks(5);
    rd(4'd9, b); chk("R5 pin ignored with comparator source", {24'h0, b}, 32'h0);
    e = cap_expect(sh_cnt); cmp_in = 1'b1; ticks(3);
    rd16(4'd2, w); chk("R5 comparator capture", {16'h0, w}, {16'h0, e});
    rd(4'd9, b); chk("R5 comparator flag", {24'h0, b}, 32'h20);

    // R8 mask layout
    wr(4'd8, 8'hFF); rd(4'd8, b);
    chk("R8 reserved bits zero", {24'h0, b}, 32'h27);
    wr(4'd8, 8'h20);

    // R10 gating and R11 acknowledge
    wr(4'd9, 8'hFF); wr(4'd10, 8'h02); cap_pin = 1'b0; ticks(5); gie = 1'b1;
    cap_pin = 1'b1; ticks(3);
    chk("R10 irq lags flag", {28'h0, irq}, 32'h0);
    tick(); chk("R10 irq asserted", {28'h0, irq}, 32'h8);
    gie = 1'b0; tick(); chk("R10 gie gates irq", {28'h0, irq}, 32'h0);
    gie = 1'b1; tick(); chk("R10 irq returns", {28'h0, irq}, 32'h8);
    irq_ack = 4'h8; tick(); irq_ack = 4'h0;
    rd(4'd9, b); chk("R11 ack clears flag", {24'h0, b}, 32'h0);
    chk("R11 irq dropped", {28'h0, irq}, 32'h0);

    // R2 overflow and R12 compare near the top of the range
    wr(4'd8, 8'h27);
    wr16(4'd4, 16'hFFF8); wr16(4'd6, 16'h1234); wr(4'd9, 8'hFF);
    wr16(4'd0, 16'hFFF0);
    chk("R7 counter load", {16'h0, sh_cnt}, 32'hFFF0);
    ticks(4);
    rd(4'd9, b); chk("R12 no match below compare", {24'h0, b}, 32'h0);
    ticks(20);
    rd(4'd9, b); chk("R2 R12 overflow and compare A", {24'h0, b}, 32'h03);
    chk("R10 overflow and compare irqs", {28'h0, irq}, 32'h3);
    wr(4'd9, 8'h01); rd(4'd9, b); chk("R9 selective clear", {24'h0, b}, 32'h02);
    e = sh_cnt; rd16(4'd0, w); chk("R2 wrapped counter", {16'h0, w}, {16'h0, e});

    // Random 16-bit traffic (R6, R7, R8)
    for (int i = 0; i < 40; i++) begin
      logic [3:0]  a;
      logic [15:0] v;
      logic [7:0]  d;
      a = 4'(2 * ($urandom % 4));
      v = 16'($urandom);
      wr16(a, v);
      if (a == 4'd0) e = sh_cnt; else e = v;
      rd16(a, w);
      chk("R7 R6 random round trip", {16'h0, w}, {16'h0, e});
      d = 8'($urandom);
      wr(4'd8, d); rd(4'd8, b);
      chk("R8 random mask", {24'h0, b}, {24'h0, d & 8'h27});
      wr(4'(2 * ($urandom % 4) + 1), d); rd(4'(2 * ($urandom % 4) + 1), b);
      chk("R7 random shared temp", {24'h0, b}, {24'h0, d});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule